// File: doc/BRIEF.md
# Short Branch Condition Evaluator

This block decides whether a short relative branch is taken and computes the instruction pointer that follows it. It covers three kinds of branch. The first is the sixteen conditional jumps, selected by a 4-bit condition code. The second is the counter-driven loop group, which includes the jump-if-counter-zero form. The third is the unconditional short jump. The caller provides the flag bits, the count register, an 8-bit displacement and the instruction pointer. That pointer has already been advanced past the displacement byte.

For the loop forms, the block also returns the updated count value. It has no handshake. A one-cycle `valid_i` strobe produces registered results with `valid_o` high on the next cycle. Between strobes the result registers keep their last values.

Top module: `short_branch_eval`

## Requirements
- R1: When a branch is taken, `next_ip_o` equals `ip_i` plus `disp_i` sign-extended to 16 bits, modulo 2^16.
- R2: When a branch is not taken, `next_ip_o` equals `ip_i` unchanged.
- R3: With `kind_i`=0, each of the codes 0, 2, 4, 8 and 10 is taken when one flag is set: 0 tests OF, 2 tests CF, 4 tests ZF, 8 tests SF and 10 tests PF. The next code up (1, 3, 5, 9, 11) is taken when that same flag is clear.
- R4: With `kind_i`=0, code 6 is taken when CF or ZF is set. Code 7 is taken when both CF and ZF are clear.
- R5: With `kind_i`=0, code 12 is taken when SF differs from OF. Code 13 is taken when SF equals OF.
- R6: With `kind_i`=0, code 14 is taken when SF differs from OF or ZF is set. Code 15 is taken when ZF is clear and SF equals OF.
- R7: With `kind_i`=1 and `cond_i[1:0]`=2 (plain loop), `cx_o` is `cx_i`-1 modulo 2^16. The branch is taken when that new value is nonzero.
- R8: With `kind_i`=1, selector 1 (loop while zero) decrements like R7 and is taken only if the new count is nonzero and ZF is set. Selector 0 (loop while nonzero) is the same except that it requires ZF clear.
- R9: With `kind_i`=1 and selector 3, the branch is taken exactly when `cx_i` is zero, and `cx_o` equals `cx_i`.
- R10: With `kind_i` equal to 2 or 3, the branch is always taken, whatever the flags and count.
- R11: The following hold for the output registers:
  - After reset, all outputs are zero.
  - `valid_o` is high exactly one cycle after `valid_i`.
  - For kinds other than 1, `cx_o` equals `cx_i`.
  - While `valid_i` is low, `taken_o`, `next_ip_o` and `cx_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Evaluation strobe |
| kind_i | input | 2 | 0 conditional jump, 1 loop group, 2 or 3 unconditional jump |
| cond_i | input | 4 | Condition code; low two bits select the loop form |
| of_i | input | 1 | Overflow flag |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| pf_i | input | 1 | Parity flag |
| cx_i | input | 16 | Count register |
| ip_i | input | 16 | Instruction pointer past the displacement |
| disp_i | input | 8 | Signed displacement |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_ip_o | output | 16 | Following instruction pointer |
| cx_o | output | 16 | Updated count register |

## Verification
Two functions can act in the same cycle: the loop group's count decrement and the target addition. A loop form rewrites the count and moves the instruction pointer on the same strobe.

The bench provokes both edge cases together. It issues a plain loop with a count of zero, which wraps to 0xFFFF and is taken. The instruction pointer is set so that the target addition also wraps past 0xFFFF. The scoreboard compares the taken bit, the pointer and the count of that single result as one item.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic [1:0] {
    KIND_JCC  = 2'd0,
    KIND_LOOP = 2'd1,
    KIND_JMP  = 2'd2,
    KIND_JMP2 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    LP_NZ    = 2'd0,
    LP_Z     = 2'd1,
    LP_PLAIN = 2'd2,
    LP_CXZ   = 2'd3
  } loop_sel_e;
endpackage

// File: rtl/sbe_cond_eval.sv
module sbe_cond_eval (
  input  logic [3:0] cond_i,
  input  logic       of_i,
  input  logic       cf_i,
  input  logic       zf_i,
  input  logic       sf_i,
  input  logic       pf_i,
  output logic       hit_o
);
  logic base;

  // odd codes invert their even partner
  always_comb begin
    unique case (cond_i[3:1])
      3'd0: base = of_i;
      3'd1: base = cf_i;
      3'd2: base = zf_i;
      3'd3: base = cf_i | zf_i;
      3'd4: base = sf_i;
      3'd5: base = pf_i;
      3'd6: base = sf_i ^ of_i;
      default: base = (sf_i ^ of_i) | zf_i;
    endcase
    hit_o = base ^ cond_i[0];
  end
endmodule

// File: rtl/sbe_loop_eval.sv
module sbe_loop_eval
  import sbe_pkg::*;
#(
  parameter int CX_W = 16
) (
  input  logic [1:0]      sel_i,
  input  logic [CX_W-1:0] cx_i,
  input  logic            zf_i,
  output logic            hit_o,
  output logic [CX_W-1:0] cx_o
);
  logic [CX_W-1:0] cx_dec;
  logic            dec_nz;

  assign cx_dec = cx_i - CX_W'(1);
  assign dec_nz = |cx_dec;

  always_comb begin
    cx_o = cx_dec;
    unique case (loop_sel_e'(sel_i))
      LP_NZ:    hit_o = dec_nz & ~zf_i;
      LP_Z:     hit_o = dec_nz & zf_i;
      LP_PLAIN: hit_o = dec_nz;
      default: begin
        hit_o = ~|cx_i;
        cx_o  = cx_i;
      end
    endcase
  end
endmodule

// File: rtl/sbe_target.sv
module sbe_target #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [IP_W-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [IP_W-1:0]   target_o
);
  logic [IP_W-1:0] disp_ext;

  generate
    if (IP_W > DISP_W) begin : g_ext
      localparam int EXT_W = IP_W - DISP_W;
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[IP_W-1:0];
    end
  endgenerate

  assign target_o = ip_i + disp_ext;
endmodule

// File: rtl/short_branch_eval.sv
module short_branch_eval
  import sbe_pkg::*;
#(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8,
  parameter int CX_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic              of_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              pf_i,
  input  logic [CX_W-1:0]   cx_i,
  input  logic [IP_W-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [IP_W-1:0]   next_ip_o,
  output logic [CX_W-1:0]   cx_o
);
  logic            jcc_hit, loop_hit, take;
  logic [CX_W-1:0] loop_cx, cx_nxt;
  logic [IP_W-1:0] target;

  sbe_cond_eval u_cond (
    .cond_i(cond_i), .of_i(of_i), .cf_i(cf_i), .zf_i(zf_i),
    .sf_i(sf_i), .pf_i(pf_i), .hit_o(jcc_hit)
  );

  sbe_loop_eval #(.CX_W(CX_W)) u_loop (
    .sel_i(cond_i[1:0]), .cx_i(cx_i), .zf_i(zf_i),
    .hit_o(loop_hit), .cx_o(loop_cx)
  );

  sbe_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
    .ip_i(ip_i), .disp_i(disp_i), .target_o(target)
  );

  always_comb begin
    unique case (kind_e'(kind_i))
      KIND_JCC:  begin take = jcc_hit;  cx_nxt = cx_i;    end
      KIND_LOOP: begin take = loop_hit; cx_nxt = loop_cx; end
      default:   begin take = 1'b1;     cx_nxt = cx_i;    end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_ip_o <= '0;
      cx_o      <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= take;
        next_ip_o <= take ? target : ip_i;
        cx_o      <= cx_nxt;
      end
    end
  end

  assert_valid_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_no_spurious_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(taken_o) && $stable(next_ip_o) && $stable(cx_o)));
  assert_not_taken_ip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd0 && !jcc_hit) |=> (next_ip_o == $past(ip_i)));
  assert_uncond_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i[1]) |=> taken_o);
  assert_cxz_keeps_cx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd1 && cond_i[1:0] == 2'd3) |=> (cx_o == $past(cx_i)));
  assert_loop_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd1 && cond_i[1:0] == 2'd2 && cx_i == CX_W'(1))
      |=> (!taken_o && cx_o == '0));
endmodule

// File: tb/sim_short_branch_eval.sv
module sim_short_branch_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [3:0]  cond_i = '0;
  logic        of_i = 0, cf_i = 0, zf_i = 0, sf_i = 0, pf_i = 0;
  logic [15:0] cx_i = '0, ip_i = '0;
  logic [7:0]  disp_i = '0;
  logic        valid_o, taken_o;
  logic [15:0] next_ip_o, cx_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    logic        taken;
    logic [15:0] ip;
    logic [15:0] cx;
    string       tag;
  } item_t;

  item_t exp_q[$];
  item_t last_exp;

  always #10 clk_i = ~clk_i;

  short_branch_eval u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
    .cond_i(cond_i), .of_i(of_i), .cf_i(cf_i), .zf_i(zf_i), .sf_i(sf_i),
    .pf_i(pf_i), .cx_i(cx_i), .ip_i(ip_i), .disp_i(disp_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_ip_o(next_ip_o), .cx_o(cx_o)
  );

  function automatic logic jcc_model(logic [3:0] c, logic o, logic cy, logic z,
                                     logic s, logic p);
    case (c)
      4'h0: return o;
      4'h1: return !o;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return z;
      4'h5: return !z;
      4'h6: return cy || z;
      4'h7: return !cy && !z;
      4'h8: return s;
      4'h9: return !s;
      4'hA: return p;
      4'hB: return !p;
      4'hC: return s != o;
      4'hD: return s == o;
      4'hE: return (s != o) || z;
      default: return !z && (s == o);
    endcase
  endfunction

  function automatic string jcc_tag(logic [3:0] c);
    if (c == 4'h6 || c == 4'h7) return "R4";
    if (c == 4'hC || c == 4'hD) return "R5";
    if (c == 4'hE || c == 4'hF) return "R6";
    return "R3";
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: called at a negedge, leaves valid_i high for one cycle
  task automatic send(logic [1:0] k, logic [3:0] c, logic [4:0] f,
                      logic [15:0] cx, logic [15:0] ip, logic [7:0] d);
    item_t e;
    logic [15:0] dec;
    dec = cx - 16'd1;
    e.cx = cx;
    if (k == 2'd0) begin
      e.taken = jcc_model(c, f[4], f[3], f[2], f[1], f[0]);
      e.tag = jcc_tag(c);
    end else if (k == 2'd1) begin
      case (c[1:0])
        2'd0: begin e.taken = (dec != 0) && !f[2]; e.cx = dec; e.tag = "R8"; end
        2'd1: begin e.taken = (dec != 0) && f[2];  e.cx = dec; e.tag = "R8"; end
        2'd2: begin e.taken = (dec != 0);          e.cx = dec; e.tag = "R7"; end
        default: begin e.taken = (cx == 0); e.tag = "R9"; end
      endcase
    end else begin
      e.taken = 1'b1;
      e.tag = "R10";
    end
    e.ip = e.taken ? ip + {{8{d[7]}}, d} : ip;
    exp_q.push_back(e);
    last_exp = e;
    valid_i = 1'b1; kind_i = k; cond_i = c;
    {of_i, cf_i, zf_i, sf_i, pf_i} = f;
    cx_i = cx; ip_i = ip; disp_i = d;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R11", "unexpected valid", 16'd1, 16'd0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(e.tag, "taken", {15'd0, taken_o}, {15'd0, e.taken});
        check(e.taken ? "R1" : "R2", {"next_ip ", e.tag}, next_ip_o, e.ip);
        check(e.tag, "cx", cx_o, e.cx);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11", "reset valid", {15'd0, valid_o}, 16'd0);
    check("R11", "reset taken", {15'd0, taken_o}, 16'd0);
    check("R11", "reset next_ip", next_ip_o, 16'd0);
    check("R11", "reset cx", cx_o, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 R5 R6: every code against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        send(2'd0, 4'(c), 5'(f), 16'h1234 ^ 16'(f), 16'h1000 + 16'(c * 64 + f),
             8'(f * 37 + c));

    // R1 wrap in both directions
    send(2'd0, 4'h4, 5'b00100, 16'h0, 16'hFFF0, 8'h7F);
    send(2'd0, 4'h4, 5'b00100, 16'h0, 16'h0005, 8'h80);

    // R7 R8 R9 loop group
    for (int s = 0; s < 4; s++)
      for (int z = 0; z < 2; z++) begin
        send(2'd1, 4'(s), z ? 5'b00100 : 5'b0, 16'h0000, 16'h2000, 8'hF0);
        send(2'd1, 4'(s), z ? 5'b00100 : 5'b0, 16'h0001, 16'h2000, 8'hF0);
        send(2'd1, 4'(s), z ? 5'b00100 : 5'b0, 16'h0002, 16'h2000, 8'h10);
        send(2'd1, 4'(s), z ? 5'b00100 : 5'b0, 16'hFFFF, 16'h2000, 8'h10);
        send(2'd1, 4'(s) | 4'hC, z ? 5'b11111 : 5'b11011, 16'h0010, 16'h3000, 8'h80);
      end

    // count wrap together with pointer wrap
    send(2'd1, 4'd2, 5'b0, 16'h0000, 16'hFFFE, 8'h05);

    // R10 unconditional
    send(2'd2, 4'h0, 5'b0, 16'h0000, 16'h4000, 8'h80);
    send(2'd3, 4'h5, 5'b00100, 16'hABCD, 16'h4000, 8'h7F);
    send(2'd2, 4'hF, 5'b11111, 16'h0001, 16'hFFFF, 8'h01);

    // R11 idle: inputs change with valid_i low, outputs must hold
    ip_i = 16'h5555; cx_i = 16'hAAAA; disp_i = 8'h33; kind_i = 2'd1;
    repeat (3) @(negedge clk_i);
    check("R11", "idle valid", {15'd0, valid_o}, 16'd0);
    check("R11", "idle taken", {15'd0, taken_o}, {15'd0, last_exp.taken});
    check("R11", "idle next_ip", next_ip_o, last_exp.ip);
    check("R11", "idle cx", cx_o, last_exp.cx);
    check("R11", "drained", 16'(exp_q.size()), 16'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule